// File: doc/BRIEF.md
# RS-485 Half-Duplex UART Transmitter

This block is the transmit half of a serial port. Bytes are written into a small transmit FIFO and sent out LSB first. Each byte goes out as an 8N1 frame: one start bit, eight data bits and one stop bit. One bit lasts from one pulse of an external bit-rate tick to the next. While the FIFO holds more bytes, the frames go out back to back with no idle time between them. The block also raises a transmit interrupt request. When software enables automatic direction control, the block also drives an active-low direction output for an RS-485 line driver.

In standard mode the interrupt fires as soon as the FIFO (the holding stage) runs dry, even while the last character is still shifting out. In this mode the direction output simply copies a software-supplied level.

In automatic mode the direction output goes low (driver on) the cycle after any byte is queued. It goes high again only after a one-bit guard time, counted with the same bit tick, that follows the stop bit of the last character. A byte written during that guard time cancels the release. The interrupt is held back until the shifter itself is idle.

Top module: `uart485_tx`

## Requirements
- R1: Each byte is sent on `txd` as a low start bit, then eight data bits LSB first, then a high stop bit. `txd` changes only on a clock edge where `bit_tick` is high, and it rests high while nothing is being sent.
- R2: If another byte is queued when a stop bit ends, its start bit begins on that same tick, with no idle bit between the frames.
- R3: The FIFO holds `DEPTH` bytes. A write while it is full is discarded, and no frame is ever sent for that byte.
- R4: With `auto_dir_en`=1, `dir_n` is 0 in the cycle after any accepted write.
- R5: With `auto_dir_en`=1, `dir_n` goes to 1 on the first tick after the tick that ends the last stop bit, i.e. one bit time later. It is still 0 at the tick that ends the stop bit.
- R6: A write accepted during that one-bit guard time cancels the release. `dir_n` stays 0, and the new frame starts on the next tick.
- R7: With `auto_dir_en`=0, `tx_irq` rises to 1 within two clocks of the FIFO becoming empty, even while the shifter is still sending.
- R8: With `auto_dir_en`=1, `tx_irq` stays 0 while a frame is shifting. It rises only after the FIFO is empty and the shifter is idle.
- R9: An accepted write clears `tx_irq` to 0 on the next clock.
- R10: With `auto_dir_en`=0, `dir_n` takes the value of `sw_dir_n` one clock later.
- R11: After reset `txd`=1, `dir_n`=1 and `tx_irq`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Write strobe into the transmit FIFO |
| wr_data | input | 8 | Byte to queue |
| auto_dir_en | input | 1 | 1 = automatic direction control, 0 = standard mode |
| sw_dir_n | input | 1 | Software direction level used in standard mode |
| txd | output | 1 | Serial line output |
| dir_n | output | 1 | Line driver direction, 0 = transmit |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with `DEPTH`=4 and a tick every 8 clocks. With this shallow FIFO, five writes fit between two ticks, so the overflow drop can be reached. The wide tick spacing leaves several clocks between edges. That lets the bench sample the guard-time window precisely, and it makes room for a write inside the guard time.

// File: rtl/uart485_pkg.sv
package uart485_pkg;
    localparam int unsigned CHAR_BITS = 8;
    typedef logic [CHAR_BITS-1:0] char_t;
endpackage

// File: rtl/uart485_fifo.sv
module uart485_fifo
    import uart485_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  char_t wr_data,
    input  logic  rd_en,
    output char_t rd_data,
    output logic  empty,
    output logic  accepted
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][CHAR_BITS-1:0] mem;
        logic [AW-1:0]                   rd;
        logic [AW-1:0]                   wr;
        logic [CW-1:0]                   cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic pop;

    always_comb begin
        s_d      = s_q;
        accepted = wr_en && (s_q.cnt != CW'(DEPTH));
        pop      = rd_en && (s_q.cnt != '0);
        if (accepted) begin
            s_d.mem[s_q.wr] = wr_data;
            s_d.wr = (s_q.wr == AW'(DEPTH - 1)) ? '0 : s_q.wr + AW'(1);
        end
        if (pop) begin
            s_d.rd = (s_q.rd == AW'(DEPTH - 1)) ? '0 : s_q.rd + AW'(1);
        end
        case ({accepted, pop})
            2'b10:   s_d.cnt = s_q.cnt + CW'(1);
            2'b01:   s_d.cnt = s_q.cnt - CW'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data = s_q.mem[s_q.rd];
    assign empty   = (s_q.cnt == '0);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));
    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CW'(DEPTH) && wr_en && !rd_en) |=> (s_q.cnt == CW'(DEPTH)));
endmodule

// File: rtl/uart485_shifter.sv
module uart485_shifter
    import uart485_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_tick,
    input  logic  avail,
    input  char_t din,
    output logic  pop,
    output logic  drained,
    output logic  busy,
    output logic  txd
);
    localparam int unsigned LAST = CHAR_BITS + 1;
    localparam int unsigned CW   = $clog2(LAST + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        char_t         sh;
        logic          txd;
    } shift_state_t;

    shift_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        pop     = 1'b0;
        drained = 1'b0;
        if (bit_tick) begin
            if (!s_q.busy || s_q.cnt == CW'(LAST)) begin
                if (avail) begin
                    pop      = 1'b1;
                    s_d.busy = 1'b1;
                    s_d.cnt  = '0;
                    s_d.sh   = din;
                    s_d.txd  = 1'b0;
                end else begin
                    drained  = s_q.busy;
                    s_d.busy = 1'b0;
                    s_d.cnt  = '0;
                    s_d.txd  = 1'b1;
                end
            end else if (s_q.cnt == CW'(CHAR_BITS)) begin
                s_d.txd = 1'b1;
                s_d.cnt = s_q.cnt + CW'(1);
            end else begin
                s_d.txd = s_q.sh[0];
                s_d.sh  = s_q.sh >> 1;
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.txd <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;
    assign txd  = s_q.txd;

    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> s_q.txd);
    // R1
    tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(s_q.txd));
endmodule

// File: rtl/uart485_dirctl.sv
module uart485_dirctl (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic auto_en,
    input  logic sw_dir_n,
    input  logic push,
    input  logic drained,
    input  logic fifo_empty,
    input  logic busy,
    output logic dir_n,
    output logic irq
);
    typedef struct packed {
        logic dir_n;
        logic guard;
        logic irq;
        logic cond_prev;
    } dir_state_t;

    dir_state_t s_d, s_q;
    logic irq_cond;

    always_comb begin
        s_d      = s_q;
        irq_cond = fifo_empty && (!auto_en || !busy);

        if (!auto_en) begin
            s_d.dir_n = sw_dir_n;
            s_d.guard = 1'b0;
        end else if (push) begin
            s_d.dir_n = 1'b0;
            s_d.guard = 1'b0;
        end else if (drained) begin
            s_d.guard = 1'b1;
        end else if (s_q.guard && bit_tick) begin
            s_d.guard = 1'b0;
            s_d.dir_n = 1'b1;
        end

        if (push)                          s_d.irq = 1'b0;
        else if (irq_cond && !s_q.cond_prev) s_d.irq = 1'b1;
        else if (!irq_cond)                s_d.irq = 1'b0;
        s_d.cond_prev = irq_cond;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.dir_n     <= 1'b1;
            s_q.guard     <= 1'b0;
            s_q.irq       <= 1'b0;
            s_q.cond_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign dir_n = s_q.dir_n;
    assign irq   = s_q.irq;

    // R4
    dir_on_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && push) |=> !s_q.dir_n);
    // R5
    release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && $past(auto_en) && $rose(s_q.dir_n)) |-> $past(bit_tick));
    // R8
    irq_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && $past(auto_en) && busy) |-> !s_q.irq);
    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !s_q.irq);
endmodule

// File: rtl/uart485_tx.sv
module uart485_tx #(
    parameter int unsigned DEPTH = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bit_tick,
    input  logic                              wr_en,
    input  logic [uart485_pkg::CHAR_BITS-1:0] wr_data,
    input  logic                              auto_dir_en,
    input  logic                              sw_dir_n,
    output logic                              txd,
    output logic                              dir_n,
    output logic                              tx_irq
);
    import uart485_pkg::*;

    char_t head;
    logic  empty, accepted, pop, drained, busy;

    uart485_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (pop),
        .rd_data  (head),
        .empty    (empty),
        .accepted (accepted)
    );

    uart485_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .avail    (!empty),
        .din      (head),
        .pop      (pop),
        .drained  (drained),
        .busy     (busy),
        .txd      (txd)
    );

    uart485_dirctl u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .auto_en    (auto_dir_en),
        .sw_dir_n   (sw_dir_n),
        .push       (accepted),
        .drained    (drained),
        .fifo_empty (empty),
        .busy       (busy),
        .dir_n      (dir_n),
        .irq        (tx_irq)
    );
endmodule

// File: tb/uart485_tx_test.sv
module uart485_tx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic auto_dir_en = 1'b0;
    logic sw_dir_n = 1'b1;
    logic txd, dir_n, tx_irq;

    int checks = 0;
    int failures = 0;
    int frames_rx = 0;
    logic [7:0] exp_q[$];
    int div = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart485_tx #(.DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_data(wr_data), .auto_dir_en(auto_dir_en), .sw_dir_n(sw_dir_n),
        .txd(txd), .dir_n(dir_n), .tx_irq(tx_irq)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            div <= 0;
            bit_tick <= 1'b0;
        end else begin
            div <= (div == 7) ? 0 : div + 1;
            bit_tick <= (div == 6);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic after_tick();
        do @(posedge clk); while (bit_tick !== 1'b1);
        #1;
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        exp_q.push_back(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: rebuild frames from txd one sample per tick, compare with queue
    logic mon_busy = 1'b0;
    int mon_idx = 0;
    logic [7:0] mon_sh = '0;
    bit b2b_pending = 0;
    always @(posedge clk) begin
        if (rst_n && bit_tick) begin
            #1;
            if (!mon_busy) begin
                if (b2b_pending) chk(txd == 1'b0, "R2", "start right after stop", txd, 0);
                b2b_pending = 0;
                if (txd == 1'b0) begin
                    mon_busy = 1'b1;
                    mon_idx = 0;
                end
            end else if (mon_idx < 8) begin
                mon_sh[mon_idx] = txd;
                mon_idx++;
            end else begin
                chk(txd == 1'b1, "R1", "stop bit", txd, 1);
                mon_busy = 1'b0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected frame", mon_sh, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(mon_sh == e, "R1", "frame data", mon_sh, e);
                end
                frames_rx++;
                b2b_pending = (exp_q.size() > 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int bad;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        chk(txd == 1'b1, "R11", "txd after reset", txd, 1);
        chk(dir_n == 1'b1, "R11", "dir_n after reset", dir_n, 1);
        chk(tx_irq == 1'b0, "R11", "tx_irq after reset", tx_irq, 0);

        // Standard mode: irq on FIFO empty while shifting (R7), sw direction (R10)
        push_byte(8'hA5);
        after_tick();
        repeat (2) @(posedge clk);
        #1;
        chk(tx_irq == 1'b1, "R7", "irq while shifting", tx_irq, 1);
        chk(txd == 1'b0, "R1", "start bit low", txd, 0);
        chk(dir_n == 1'b1, "R10", "dir follows sw 1", dir_n, 1);
        @(negedge clk); sw_dir_n = 1'b0;
        @(posedge clk); #1;
        chk(dir_n == 1'b0, "R10", "dir follows sw 0", dir_n, 0);
        @(negedge clk); sw_dir_n = 1'b1;
        wait (frames_rx == 1);
        after_tick(); after_tick();
        chk(tx_irq == 1'b1, "R7", "irq held when idle", tx_irq, 1);
        push_byte(8'h3C);
        chk(tx_irq == 1'b0, "R9", "irq cleared by write", tx_irq, 0);
        wait (frames_rx == 2);

        // Overflow: five writes inside one bit period, depth four (R3, R2)
        after_tick(); after_tick();
        after_tick();
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            wr_en = 1'b1;
            wr_data = 8'h10 + 8'(i);
            if (i < 4) exp_q.push_back(8'h10 + 8'(i));
            @(negedge clk);
        end
        wr_en = 1'b0;
        wait (frames_rx == 6);
        repeat (15) after_tick();
        chk(exp_q.size() == 0, "R3", "no pending expected", exp_q.size(), 0);
        chk(frames_rx == 6, "R3", "dropped byte never sent", frames_rx, 6);

        // Auto direction: assert on write, deferred irq, one-bit guard (R4 R5 R8)
        @(negedge clk); auto_dir_en = 1'b1;
        push_byte(8'h5A);
        chk(dir_n == 1'b0, "R4", "dir low after write", dir_n, 0);
        after_tick(); after_tick(); after_tick();
        chk(tx_irq == 1'b0, "R8", "no irq mid-frame", tx_irq, 0);
        wait (frames_rx == 7);
        chk(tx_irq == 1'b0, "R8", "no irq during stop bit", tx_irq, 0);
        after_tick();
        repeat (2) @(posedge clk);
        #1;
        chk(tx_irq == 1'b1, "R8", "irq once shifter idle", tx_irq, 1);
        chk(dir_n == 1'b0, "R5", "dir low through guard", dir_n, 0);
        after_tick();
        chk(dir_n == 1'b1, "R5", "dir released one bit later", dir_n, 1);

        // Write inside guard time cancels release (R6)
        push_byte(8'h81);
        wait (frames_rx == 8);
        after_tick();
        push_byte(8'h7E);
        after_tick();
        chk(dir_n == 1'b0, "R6", "dir kept low", dir_n, 0);
        chk(txd == 1'b0, "R6", "new start bit", txd, 0);
        wait (frames_rx == 9);
        after_tick(); after_tick();
        chk(dir_n == 1'b1, "R6", "released after second frame", dir_n, 1);

        // Burst of three in auto mode, direction never drops (R2, R4)
        push_byte(8'hC3);
        push_byte(8'h00);
        push_byte(8'hFF);
        bad = 0;
        while (frames_rx < 12) begin
            after_tick();
            if (dir_n !== 1'b0) bad++;
        end
        chk(bad == 0, "R4", "dir low over burst", bad, 0);
        repeat (3) after_tick();
        chk(dir_n == 1'b1, "R5", "dir released after burst", dir_n, 1);
        chk(exp_q.size() == 0, "R1", "all frames seen", exp_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule